// File: doc/BRIEF.md
# Fixed Main Memory Region Decoder

This block sits between a processor's 16-bit address bus and the memories and devices of a fixed, unmapped address space. Each cycle it classifies the presented address into one of thirteen regions, gives the byte offset of the address within that region, and applies each region's access rules. The result is registered, so its outputs describe the address presented one clock earlier.

The decode is not a pure range split. A program ROM can shadow the upper RAM for reads while writes still reach the RAM beneath it. A buffer shared with a second processor is usable only while that processor is halted. A two-bit boot code picks one of four boot images. An initialization ROM can overlay two separate ranges. The memory arrays and any page mapping live outside the block.

Region indices, which are also the bit positions of `region_sel`: 0 lower RAM, 1 upper RAM, 2 program ROM, 3 work RAM, 4 shared buffer, 5 I/O window, 6 boot image A, 7 boot image B, 8 boot RAM, 9 boot image X, 10 vector RAM, 11 reset vector, 12 initialization ROM.

Top module: `fixmem_decoder`

## Requirements
- R1: Addresses 0x0000–0x7FFF select lower RAM (bit 0) with an offset equal to the address, and writes are permitted.
- R2: For a read in 0x8000–0xFBFF, the decoder selects the program ROM (bit 2) when `rom_visible` is 1 and the upper RAM (bit 1) when it is 0. The offset is the address minus 0x8000.
- R3: A write in 0x8000–0xFBFF selects the upper RAM (bit 1) with `write_ok` = 1 whatever `rom_visible` is. The offset is the address minus 0x8000.
- R4: The decoder selects work RAM (bit 3) for 0xFC00–0xFC7F and the I/O window (bit 5) for 0xFD00–0xFDFF. Each offset is measured from its region's base, and writes to both regions are permitted.
- R5: Addresses 0xFC80–0xFCFF select the shared buffer (bit 4) with an offset from 0xFC80. While `sub_halted` is 0, a read raises `force_ff` and a write gives `write_ok` = 0. While `sub_halted` is 1, a read gives `force_ff` = 0 and a write gives `write_ok` = 1.
- R6: Addresses 0xFE00–0xFFDF select a boot region by `boot_mode`, with an offset from 0xFE00. The codes map as follows: 0 → image A (bit 6), 1 → image B (bit 7), 2 → boot RAM (bit 8), 3 → image X (bit 9). A write is permitted only for code 2 with `bootram_we` = 1.
- R7: Addresses 0xFFE0–0xFFFD select the vector RAM (bit 10), which is writable, with an offset from 0xFFE0. Addresses 0xFFFE–0xFFFF select the read-only reset vector (bit 11) with offsets 0 and 1; the attached store returns 0xFE at offset 0 and 0x00 at offset 1.
- R8: When `init_overlay` is 1, the initialization ROM (bit 12) is selected for 0x6000–0x7FFF with offset address−0x6000, and for 0xE000–0xFFFF with offset address−0xE000. This takes priority over every other rule.
- R9: Exactly one bit of `region_sel` is set in every cycle.
- R10: `write_ok` is never 1 while a ROM region (bits 2, 6, 7, 9, 11, 12) is selected, so writes there have no effect.
- R11: Outputs follow the inputs after one clock edge. In reset, `region_sel` = 0x0001, `offset` = 0, and `write_ok` = `force_ff` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| wr | input | 1 | 1 = write access, 0 = read access |
| rom_visible | input | 1 | Program ROM visible for reads in the upper range |
| boot_mode | input | 2 | Boot image selector code |
| bootram_we | input | 1 | Write enable for the boot RAM |
| sub_halted | input | 1 | Second processor is halted |
| init_overlay | input | 1 | Initialization ROM overlay enable |
| region_sel | output | 13 | One-hot region select |
| offset | output | 16 | Offset of the address within the selected region |
| write_ok | output | 1 | The current write may be carried out |
| force_ff | output | 1 | The current read must return 0xFF |

## Verification
An error in the decoder shows up at the ports exactly one cycle after the address that triggers it. It appears as a wrong select bit, a select that is not one-hot, an offset measured from the wrong base, or a gating flag that lets a ROM or shared-buffer write through. The bench sweeps every address twice under flag settings that change from address to address. It compares every registered result against an arithmetic model, so a faulty boundary or gating term is exposed on the first address that reaches it.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [3:0] {
        RG_LRAM     = 4'd0,
        RG_URAM     = 4'd1,
        RG_ROM      = 4'd2,
        RG_WORK     = 4'd3,
        RG_SHARE    = 4'd4,
        RG_IO       = 4'd5,
        RG_BOOT_A   = 4'd6,
        RG_BOOT_B   = 4'd7,
        RG_BOOT_RAM = 4'd8,
        RG_BOOT_X   = 4'd9,
        RG_VEC      = 4'd10,
        RG_RSTV     = 4'd11,
        RG_INIT     = 4'd12
    } region_e;

    localparam int NREG = 13;

    // region bases (ascending order is behaviour: the decode walks them)
    localparam logic [ADDR_W-1:0] B_URAM  = 16'h8000;
    localparam logic [ADDR_W-1:0] B_WORK  = 16'hFC00;
    localparam logic [ADDR_W-1:0] B_SHARE = 16'hFC80;
    localparam logic [ADDR_W-1:0] B_IO    = 16'hFD00;
    localparam logic [ADDR_W-1:0] B_BOOT  = 16'hFE00;
    localparam logic [ADDR_W-1:0] B_VEC   = 16'hFFE0;
    localparam logic [ADDR_W-1:0] B_RSTV  = 16'hFFFE;
    localparam logic [ADDR_W-1:0] B_OVL_LO = 16'h6000;
    localparam logic [ADDR_W-1:0] B_OVL_HI = 16'hE000;

    localparam logic [1:0] BM_IMG_A = 2'd0;
    localparam logic [1:0] BM_IMG_B = 2'd1;
    localparam logic [1:0] BM_RAM   = 2'd2;

    typedef struct packed {
        logic [NREG-1:0]   sel;
        logic [ADDR_W-1:0] ofs;
        logic              wr_ok;
        logic              ff;
    } dec_out_t;

    function automatic logic is_rom(input region_e r);
        return (r == RG_ROM) || (r == RG_BOOT_A) || (r == RG_BOOT_B) ||
               (r == RG_BOOT_X) || (r == RG_RSTV) || (r == RG_INIT);
    endfunction

endpackage

// File: rtl/fmd_range.sv
module fmd_range
    import fmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rom_visible,
    input  logic [1:0]        boot_mode,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] base;

    always_comb begin
        region = RG_LRAM;
        base   = '0;
        if (addr < B_URAM) begin
            region = RG_LRAM;
            base   = '0;
        end else if (addr < B_WORK) begin
            // reads see the ROM when visible, writes always land in RAM
            region = (rom_visible && !wr) ? RG_ROM : RG_URAM;
            base   = B_URAM;
        end else if (addr < B_SHARE) begin
            region = RG_WORK;
            base   = B_WORK;
        end else if (addr < B_IO) begin
            region = RG_SHARE;
            base   = B_SHARE;
        end else if (addr < B_BOOT) begin
            region = RG_IO;
            base   = B_IO;
        end else if (addr < B_VEC) begin
            base = B_BOOT;
            unique case (boot_mode)
                BM_IMG_A: region = RG_BOOT_A;
                BM_IMG_B: region = RG_BOOT_B;
                BM_RAM:   region = RG_BOOT_RAM;
                default:  region = RG_BOOT_X;
            endcase
        end else if (addr < B_RSTV) begin
            region = RG_VEC;
            base   = B_VEC;
        end else begin
            region = RG_RSTV;
            base   = B_RSTV;
        end
    end

    assign offset = addr - base;

endmodule

// File: rtl/fmd_overlay.sv
module fmd_overlay
    import fmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              init_overlay,
    input  region_e           region_in,
    input  logic [ADDR_W-1:0] offset_in,
    output region_e           region_out,
    output logic [ADDR_W-1:0] offset_out
);

    logic hit_lo, hit_hi;

    assign hit_lo = init_overlay && (addr >= B_OVL_LO) && (addr < B_URAM);
    assign hit_hi = init_overlay && (addr >= B_OVL_HI);

    always_comb begin
        region_out = region_in;
        offset_out = offset_in;
        if (hit_lo) begin
            region_out = RG_INIT;
            offset_out = addr - B_OVL_LO;
        end else if (hit_hi) begin
            region_out = RG_INIT;
            offset_out = addr - B_OVL_HI;
        end
    end

endmodule

// File: rtl/fmd_gate.sv
module fmd_gate
    import fmd_pkg::*;
(
    input  region_e region,
    input  logic    wr,
    input  logic    bootram_we,
    input  logic    sub_halted,
    output logic    write_ok,
    output logic    force_ff
);

    logic writable;

    always_comb begin
        unique case (region)
            RG_LRAM, RG_URAM, RG_WORK, RG_IO, RG_VEC: writable = 1'b1;
            RG_SHARE:                                 writable = sub_halted;
            RG_BOOT_RAM:                              writable = bootram_we;
            default:                                  writable = 1'b0;
        endcase
    end

    assign write_ok = wr && writable;
    assign force_ff = !wr && (region == RG_SHARE) && !sub_halted;

endmodule

// File: rtl/fixmem_decoder.sv
module fixmem_decoder
    import fmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rom_visible,
    input  logic [1:0]        boot_mode,
    input  logic              bootram_we,
    input  logic              sub_halted,
    input  logic              init_overlay,
    output logic [NREG-1:0]   region_sel,
    output logic [ADDR_W-1:0] offset,
    output logic              write_ok,
    output logic              force_ff
);

    region_e           rng_region, fin_region;
    logic [ADDR_W-1:0] rng_ofs, fin_ofs;
    logic              gate_wr_ok, gate_ff;
    logic [NREG-1:0]   sel_vec;
    dec_out_t          out_d, out_q;

    fmd_range u_range (
        .addr        (addr),
        .wr          (wr),
        .rom_visible (rom_visible),
        .boot_mode   (boot_mode),
        .region      (rng_region),
        .offset      (rng_ofs)
    );

    fmd_overlay u_overlay (
        .addr         (addr),
        .init_overlay (init_overlay),
        .region_in    (rng_region),
        .offset_in    (rng_ofs),
        .region_out   (fin_region),
        .offset_out   (fin_ofs)
    );

    fmd_gate u_gate (
        .region     (fin_region),
        .wr         (wr),
        .bootram_we (bootram_we),
        .sub_halted (sub_halted),
        .write_ok   (gate_wr_ok),
        .force_ff   (gate_ff)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel_vec[g] = (fin_region == region_e'(g));
    end

    always_comb begin
        out_d       = out_q;
        out_d.sel   = sel_vec;
        out_d.ofs   = fin_ofs;
        out_d.wr_ok = gate_wr_ok;
        out_d.ff    = gate_ff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q       <= '0;
            out_q.sel   <= NREG'(1);
        end else begin
            out_q <= out_d;
        end
    end

    assign region_sel = out_q.sel;
    assign offset     = out_q.ofs;
    assign write_ok   = out_q.wr_ok;
    assign force_ff   = out_q.ff;

    // select is always one-hot (R9)
    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(region_sel) == 1);

    // no write permission while a ROM region is selected (R10)
    assert_rom_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel[RG_ROM] || region_sel[RG_BOOT_A] || region_sel[RG_BOOT_B] ||
         region_sel[RG_BOOT_X] || region_sel[RG_RSTV] || region_sel[RG_INIT])
        |-> !write_ok);

    // forced 0xFF only on the shared buffer, never together with a write (R5)
    assert_ff_share_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_ff |-> (region_sel[RG_SHARE] && !write_ok));

    // reset vector has two bytes (R7)
    assert_rstv_ofs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_RSTV] |-> (offset < 16'd2));

    // work RAM offset stays inside its 128 bytes (R4)
    assert_work_ofs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_WORK] |-> (offset < 16'h0080));

    // program ROM offset stays below the top of its range (R2)
    assert_rom_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_ROM] |-> (offset < 16'h7C00));

    // initialization ROM offset stays inside its 8 KiB (R8)
    assert_init_ofs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_INIT] |-> (offset < 16'h2000));

endmodule

// File: tb/fixmem_decoder_tb.sv
module fixmem_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0, rom_visible = 1'b0, bootram_we = 1'b0;
    logic        sub_halted = 1'b0, init_overlay = 1'b0;
    logic [1:0]  boot_mode = '0;
    logic [12:0] region_sel;
    logic [15:0] offset;
    logic        write_ok, force_ff;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fixmem_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr),
        .rom_visible(rom_visible), .boot_mode(boot_mode),
        .bootram_we(bootram_we), .sub_halted(sub_halted),
        .init_overlay(init_overlay), .region_sel(region_sel),
        .offset(offset), .write_ok(write_ok), .force_ff(force_ff)
    );

    // expected values of the last applied stimulus
    int          e_reg;
    logic [15:0] e_ofs;
    logic        e_wr, e_ff;
    string       e_tag;

    task automatic model(input logic [15:0] a, input logic w, input logic rv,
                         input logic [1:0] bm, input logic bre, input logic h,
                         input logic ov);
        int ai = int'(a);
        e_ff = 1'b0;
        if (ov && ai >= 'h6000 && ai < 'h8000) begin
            e_reg = 12; e_ofs = 16'(ai - 'h6000); e_wr = 0; e_tag = "R8";
        end else if (ov && ai >= 'hE000) begin
            e_reg = 12; e_ofs = 16'(ai - 'hE000); e_wr = 0; e_tag = "R8";
        end else if (ai < 'h8000) begin
            e_reg = 0; e_ofs = a; e_wr = w; e_tag = "R1";
        end else if (ai < 'hFC00) begin
            e_ofs = 16'(ai - 'h8000);
            if (w) begin e_reg = 1; e_wr = 1; e_tag = "R3"; end
            else begin e_reg = rv ? 2 : 1; e_wr = 0; e_tag = "R2"; end
        end else if (ai < 'hFC80) begin
            e_reg = 3; e_ofs = 16'(ai - 'hFC00); e_wr = w; e_tag = "R4";
        end else if (ai < 'hFD00) begin
            e_reg = 4; e_ofs = 16'(ai - 'hFC80); e_wr = w & h; e_ff = !w & !h; e_tag = "R5";
        end else if (ai < 'hFE00) begin
            e_reg = 5; e_ofs = 16'(ai - 'hFD00); e_wr = w; e_tag = "R4";
        end else if (ai < 'hFFE0) begin
            e_reg = 6 + int'(bm); e_ofs = 16'(ai - 'hFE00);
            e_wr = w & (bm == 2'd2) & bre; e_tag = "R6";
        end else if (ai < 'hFFFE) begin
            e_reg = 10; e_ofs = 16'(ai - 'hFFE0); e_wr = w; e_tag = "R7";
        end else begin
            e_reg = 11; e_ofs = 16'(ai - 'hFFFE); e_wr = 0; e_tag = "R7";
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic w, input logic rv,
                         input logic [1:0] bm, input logic bre, input logic h,
                         input logic ov);
        addr = a; wr = w; rom_visible = rv; boot_mode = bm;
        bootram_we = bre; sub_halted = h; init_overlay = ov;
        model(a, w, rv, bm, bre, h, ov);
    endtask

    task automatic check_out();
        logic [12:0] es = 13'(1) << e_reg;
        n_chk++;
        if (region_sel !== es || offset !== e_ofs || write_ok !== e_wr || force_ff !== e_ff) begin
            n_fail++;
            $display("FAIL %s addr=%h: got sel=%h ofs=%h wr_ok=%b ff=%b exp sel=%h ofs=%h wr_ok=%b ff=%b",
                     e_tag, addr, region_sel, offset, write_ok, force_ff, es, e_ofs, e_wr, e_ff);
        end
        n_chk++;
        if ($countones(region_sel) != 1) begin
            n_fail++;
            $display("FAIL R9 sel=%h exp one bit set", region_sel);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired, got hang exp completion");
            finish_run();
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        n_chk++;
        if (region_sel !== 13'h0001 || offset !== 16'h0 || write_ok !== 1'b0 || force_ff !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset got sel=%h ofs=%h wr_ok=%b ff=%b exp 0001/0000/0/0",
                     region_sel, offset, write_ok, force_ff);
        end
        rst_n = 1'b1;

        // R11: one-cycle latency, output only after the next edge
        apply(16'hFFFF, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        #1;
        n_chk++;
        if (region_sel !== 13'h0001) begin
            n_fail++;
            $display("FAIL R11 early change got sel=%h exp 0001", region_sel);
        end
        @(negedge clk);
        check_out();

        // R10: write to the reset vector and ROM have no permission
        apply(16'hFFFE, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        n_chk++;
        if (write_ok !== 1'b0) begin
            n_fail++; $display("FAIL R10 reset vector write got wr_ok=%b exp 0", write_ok);
        end
        apply(16'hFE10, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        n_chk++;
        if (write_ok !== 1'b0) begin
            n_fail++; $display("FAIL R10 boot image write got wr_ok=%b exp 0", write_ok);
        end
        apply(16'h7000, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        n_chk++;
        if (write_ok !== 1'b0) begin
            n_fail++; $display("FAIL R10 init overlay write got wr_ok=%b exp 0", write_ok);
        end

        // two full address sweeps with flags varying by address (R1..R9)
        for (int i = 0; i < 131072; i++) begin
            logic [15:0] a = 16'(i);
            logic p = i[16];
            apply(a, a[0] ^ a[7] ^ p, a[1] ^ a[8] ^ p, {a[4] ^ p, a[5]},
                  a[6] ^ a[2], a[2] ^ a[10], a[3] & a[6] & (a[11] ^ p));
            @(negedge clk);
            check_out();
        end
        finish_run();
    end

endmodule